// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor's bus and its memories. Every cycle it looks at the 16-bit address and the bus strobes. It raises exactly one region enable for a memory cycle: program ROM, shared RAM, one of six supervisor windows, or one of three banked areas. It also produces the physical address that the selected device should see. Two small registers, loaded by I/O writes, choose the RAM bank used by the banked areas and the ROM page used by the program store.

Two windows are protected: the first supervisor window and the protected RAM area. They stay closed until the processor makes a memory access to the key address 0x1FFF. That access opens them for exactly one following access to a protected window. A protected access made while closed is neutralised: its write strobe is withheld, the read data is overridden with 0xFF, and a single-cycle violation pulse is raised. A bus access is recognised on the first cycle its read or write strobe is low during a memory request. Consecutive accesses are separated by at least one cycle with both strobes high.

Top module: `bank_mem_decoder`

## Requirements
- R1: A memory cycle with address 0x0000–0x9FFF raises `rom_sel`, and `phys_addr` is {ROM page (2 bits), address (16 bits)}.
- R2: Address 0xA000–0xBFFF raises `shr_sel`, and `phys_addr` is the address's low 13 bits, zero-extended.
- R3: Address 0xC000–0xEFFF raises exactly one bit of `sup_sel`: bit k for 0xC000+k·0x800 up to 0xC7FF+k·0x800. `phys_addr` is address−0xC000, zero-extended.
- R4: Address 0xF000–0xF7FF raises `prot_sel`, 0xF800–0xF8FF raises `scr_sel`, and 0xF900–0xFFFF raises `ram_sel`. For all three, `phys_addr` is {bank (3 bits), address[11:0]}, zero-extended to 18 bits.
- R5: No region enable is high and `phys_addr` is 0 unless `mreq_n` is low and `rfsh_n` is high. At most one enable is high in any cycle.
- R6: An I/O write, meaning `iorq_n`=0, `mreq_n`=1 and `wr_n`=0, whose address low byte is 0xDC loads the RAM bank from `wdata` if the value is 0–4. Values above 4 leave the bank unchanged. Reset sets the bank to 0.
- R7: An I/O write whose address low byte is 0xDD loads the ROM page, shown on `rom_page`, if the value is 0–3, and is ignored otherwise. The upper address byte is not compared. I/O decoding never happens while `mreq_n` is low. Reset sets the page to 0.
- R8: `mem_wr_n` is low only during a memory write to a selected, permitted, non-ROM region. Writes to ROM addresses never drive it low.
- R9: A protected-window access while closed keeps `mem_wr_n` high. When it is a read, `rd_ovr` is high and `rd_ovr_data` is 0xFF for every cycle of the access. `viol` is high for only the access's first cycle.
- R10: A memory access to 0x1FFF opens the lock from the next access on. The first later access to a protected window is permitted and closes the lock. Accesses to unprotected regions leave it open.
- R11: Permission is decided on an access's first cycle and held for all of its cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Processor address |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| wdata | input | 8 | Processor write data |
| rom_sel | output | 1 | ROM region enable |
| shr_sel | output | 1 | Shared RAM enable |
| sup_sel | output | 6 | Supervisor window enables |
| prot_sel | output | 1 | Protected banked RAM enable |
| scr_sel | output | 1 | Scratch banked RAM enable |
| ram_sel | output | 1 | General banked RAM enable |
| phys_addr | output | 18 | Physical address for the selected device |
| rom_page | output | 2 | Current ROM page |
| mem_wr_n | output | 1 | Gated memory write strobe, active low |
| rd_ovr | output | 1 | Read data override active |
| rd_ovr_data | output | 8 | Override byte (0xFF while active) |
| viol | output | 1 | Protected-access violation pulse |

## Verification
A corrupted bank register appears in `phys_addr` on the very next cycle that selects a banked area. A corrupted page register appears on `rom_page` at once. A lock flag left in the wrong state shows up on the next protected access: a violation that should not happen, or a write and read that should have been blocked. Because of this, the bench sets up protected accesses directly before and after each unlock and each unprotected access. A per-access permission bit that fails to hold shows up in the second cycle of a multi-cycle protected access. The bench therefore drives protected accesses that last three cycles.

// File: rtl/bdec_pkg.sv
// Package: shared constants and the region-select type of the banked
// memory map decoder. Assumes a 16-bit address space.
package bdec_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int SUP_N     = 6;
    localparam int SUP_SPAN  = 'h800;
    localparam logic [ADDR_W-1:0] SHR_BASE = 16'hA000;
    localparam logic [ADDR_W-1:0] SUP_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] PRT_BASE = 16'hF000;
    localparam logic [ADDR_W-1:0] SCR_BASE = 16'hF800;
    localparam logic [ADDR_W-1:0] RAM_BASE = 16'hF900;

    typedef struct packed {
        logic             rom;
        logic             shr;
        logic [SUP_N-1:0] sup;
        logic             prot;
        logic             scr;
        logic             ram;
    } region_t;
endpackage

// File: rtl/bdec_region_decode.sv
// Module: fixed address decode into one region enable.
// Assumes: sel_ok already combines memory request and not-refresh.
// Also flags addresses inside protected windows, ungated.
module bdec_region_decode
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_ok,
    output region_t           rgn,
    output logic              in_locked
);
    logic [SUP_N-1:0] sup_hit;

    // One comparator pair per supervisor window.
    for (genvar k = 0; k < SUP_N; k++) begin : g_sup
        localparam logic [ADDR_W-1:0] LO = SUP_BASE + ADDR_W'(k * SUP_SPAN);
        localparam logic [ADDR_W-1:0] HI = SUP_BASE + ADDR_W'((k + 1) * SUP_SPAN);
        assign sup_hit[k] = (addr >= LO) && (addr < HI);
    end

    // Priority-free range decode; ranges are disjoint.
    always_comb begin
        rgn = '0;
        if (sel_ok) begin
            if (addr < SHR_BASE)      rgn.rom  = 1'b1;
            else if (addr < SUP_BASE) rgn.shr  = 1'b1;
            else if (addr < PRT_BASE) rgn.sup  = sup_hit;
            else if (addr < SCR_BASE) rgn.prot = 1'b1;
            else if (addr < RAM_BASE) rgn.scr  = 1'b1;
            else                      rgn.ram  = 1'b1;
        end
    end

    // Protected windows: first supervisor window and protected RAM.
    always_comb begin
        in_locked = sup_hit[0] || ((addr >= PRT_BASE) && (addr < SCR_BASE));
    end

    assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgn));
    assert_sup_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rgn.sup) |-> (addr >= SUP_BASE) && (addr < PRT_BASE));
endmodule

// File: rtl/bdec_port_regs.sv
// Module: RAM bank and ROM page registers loaded by I/O writes.
// Assumes: only the low address byte names a port. Out-of-range
// values are dropped and the old setting kept.
module bdec_port_regs
    import bdec_pkg::*;
#(
    parameter int BANK_COUNT = 5,
    parameter int PAGE_COUNT = 4,
    parameter logic [7:0] BANK_PORT = 8'hDC,
    parameter logic [7:0] PAGE_PORT = 8'hDD,
    localparam int BANK_W = $clog2(BANK_COUNT),
    localparam int PAGE_W = $clog2(PAGE_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        port,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank,
    output logic [PAGE_W-1:0] page
);
    logic io_wr;

    // An I/O write cycle in progress.
    always_comb io_wr = !iorq_n && mreq_n && !wr_n;

    // Bank register: loads only legal bank numbers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (io_wr && port == BANK_PORT && wdata < DATA_W'(BANK_COUNT))
            bank <= wdata[BANK_W-1:0];
    end

    // Page register: loads only legal page numbers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (io_wr && port == PAGE_PORT && wdata < DATA_W'(PAGE_COUNT))
            page <= wdata[PAGE_W-1:0];
    end

    assert_bank_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bank) < BANK_COUNT);
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr || port != BANK_PORT) |=> $stable(bank));
    assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr || port != PAGE_PORT) |=> $stable(page));
endmodule

// File: rtl/bdec_lock_ctrl.sv
// Module: one-shot unlock for protected windows.
// Assumes: accesses are separated by at least one idle strobe cycle.
// Permission is taken on the first cycle of an access and held.
module bdec_lock_ctrl
    import bdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_locked,
    output logic              permit,
    output logic              viol
);
    logic strobe_q;
    logic open_q;
    logic pass_q;
    logic start;

    // First cycle of a memory access.
    always_comb start = strobe && !strobe_q;

    // Permission valid in the current cycle.
    always_comb permit = start ? open_q : pass_q;

    // Violation flagged on the first cycle of a refused access.
    always_comb viol = start && in_locked && !open_q;

    // Access-edge tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Lock state: key opens, protected access consumes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (start && in_locked)
            open_q <= 1'b0;
        else if (start && addr == KEY_ADDR)
            open_q <= 1'b1;
    end

    // Held permission for the rest of the access.
    always_ff @(posedge clk) begin
        if (!rst_n)     pass_q <= 1'b0;
        else if (start) pass_q <= open_q;
    end

    assert_viol_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !viol);
    assert_close_after_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && in_locked) |=> !open_q);
    assert_open_by_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(addr) == KEY_ADDR);
    assert_permit_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !start) |-> permit == $past(permit));
endmodule

// File: rtl/bank_mem_decoder.sv
// Module: top of the banked memory map decoder. Gates region enables,
// forms the physical address, filters the write strobe and forces
// read data on refused protected reads.
// Assumes: processor-style active-low strobes sampled on clk.
module bank_mem_decoder
    import bdec_pkg::*;
#(
    parameter int BANK_COUNT = 5,
    parameter int PAGE_COUNT = 4,
    localparam int BANK_W = $clog2(BANK_COUNT),
    localparam int PAGE_W = $clog2(PAGE_COUNT),
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rfsh_n,
    input  logic [7:0]        wdata,
    output logic              rom_sel,
    output logic              shr_sel,
    output logic [5:0]        sup_sel,
    output logic              prot_sel,
    output logic              scr_sel,
    output logic              ram_sel,
    output logic [17:0]       phys_addr,
    output logic [1:0]        rom_page,
    output logic              mem_wr_n,
    output logic              rd_ovr,
    output logic [7:0]        rd_ovr_data,
    output logic              viol
);
    region_t           rgn;
    logic              sel_ok;
    logic              strobe;
    logic              in_locked;
    logic              permit;
    logic              denied;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] sup_off;

    // Memory cycle qualifiers.
    always_comb begin
        sel_ok = !mreq_n && rfsh_n;
        strobe = sel_ok && (!rd_n || !wr_n);
    end

    bdec_region_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .sel_ok    (sel_ok),
        .rgn       (rgn),
        .in_locked (in_locked)
    );

    bdec_port_regs #(
        .BANK_COUNT (BANK_COUNT),
        .PAGE_COUNT (PAGE_COUNT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .port   (addr[7:0]),
        .iorq_n (iorq_n),
        .mreq_n (mreq_n),
        .wr_n   (wr_n),
        .wdata  (wdata),
        .bank   (bank),
        .page   (page)
    );

    bdec_lock_ctrl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .addr      (addr),
        .in_locked (in_locked),
        .permit    (permit),
        .viol      (viol)
    );

    // Refusal of the current protected access.
    always_comb denied = strobe && in_locked && !permit;

    // Region enables to ports.
    always_comb begin
        rom_sel  = rgn.rom;
        shr_sel  = rgn.shr;
        sup_sel  = rgn.sup;
        prot_sel = rgn.prot;
        scr_sel  = rgn.scr;
        ram_sel  = rgn.ram;
        rom_page = page;
    end

    // Physical address per selected region.
    always_comb begin
        sup_off = addr - SUP_BASE;
        if (rgn.rom)
            phys_addr = {page, addr};
        else if (rgn.shr)
            phys_addr = PHYS_W'(addr[12:0]);
        else if (|rgn.sup)
            phys_addr = PHYS_W'(sup_off[13:0]);
        else if (rgn.prot || rgn.scr || rgn.ram)
            phys_addr = PHYS_W'({bank, addr[11:0]});
        else
            phys_addr = '0;
    end

    // Write strobe filter and forced read data.
    always_comb begin
        mem_wr_n    = !(strobe && !wr_n && !rgn.rom && !denied && (rgn != '0));
        rd_ovr      = denied && !rd_n;
        rd_ovr_data = rd_ovr ? 8'hFF : 8'h00;
    end

    assert_idle_no_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !rfsh_n) |-> (rgn == '0));
    assert_rom_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rgn.rom |-> mem_wr_n);
    assert_refused_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> mem_wr_n);
endmodule

// File: tb/bank_mem_decoder_test.sv
module bank_mem_decoder_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
    logic [7:0]  wdata = 8'h0;
    logic        rom_sel, shr_sel, prot_sel, scr_sel, ram_sel;
    logic [5:0]  sup_sel;
    logic [17:0] phys_addr;
    logic [1:0]  rom_page;
    logic        mem_wr_n, rd_ovr, viol;
    logic [7:0]  rd_ovr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    int  m_bank = 0, m_page = 0;
    bit  m_open = 0, m_pass = 0, m_prev = 0;

    bank_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .wdata(wdata),
        .rom_sel(rom_sel), .shr_sel(shr_sel), .sup_sel(sup_sel), .prot_sel(prot_sel),
        .scr_sel(scr_sel), .ram_sel(ram_sel), .phys_addr(phys_addr), .rom_page(rom_page),
        .mem_wr_n(mem_wr_n), .rd_ovr(rd_ovr), .rd_ovr_data(rd_ovr_data), .viol(viol)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic bit is_locked(input int a);
        return (a >= 'hC000 && a < 'hC800) || (a >= 'hF000 && a < 'hF800);
    endfunction

    function automatic bit m_strobe();
        return !mreq_n && rfsh_n && (!rd_n || !wr_n);
    endfunction

    // Reference update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank = 0; m_page = 0; m_open = 0; m_pass = 0; m_prev = 0;
        end else begin
            bit st;
            st = m_strobe() && !m_prev;
            if (!iorq_n && mreq_n && !wr_n) begin
                if (addr[7:0] == 8'hDC && wdata < 5) m_bank = wdata;
                if (addr[7:0] == 8'hDD && wdata < 4) m_page = wdata;
            end
            if (st && is_locked(addr)) begin
                m_pass = m_open; m_open = 0;
            end else if (st) begin
                m_pass = m_open;
                if (addr == 16'h1FFF) m_open = 1;
            end
            m_prev = m_strobe();
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference for the present inputs.
    task automatic compare();
        bit ok, st, permit, denied;
        int a;
        logic [10:0] sel;
        logic [17:0] ph;
        a = addr;
        ok = !mreq_n && rfsh_n;
        st = m_strobe() && !m_prev;
        permit = st ? m_open : m_pass;
        denied = m_strobe() && is_locked(a) && !permit;
        sel = '0; ph = '0;
        if (ok) begin
            if (a < 'hA000)      begin sel[10] = 1; ph = {2'(m_page), addr}; end
            else if (a < 'hC000) begin sel[9] = 1;  ph = 18'(a - 'hA000); end
            else if (a < 'hF000) begin sel[3 + (a - 'hC000) / 'h800] = 1; ph = 18'(a - 'hC000); end
            else if (a < 'hF800) begin sel[2] = 1; ph = 18'(m_bank * 4096 + (a % 4096)); end
            else if (a < 'hF900) begin sel[1] = 1; ph = 18'(m_bank * 4096 + (a % 4096)); end
            else                 begin sel[0] = 1; ph = 18'(m_bank * 4096 + (a % 4096)); end
        end
        check("R1 R2 R3 R4 R5 region enables",
              {rom_sel, shr_sel, sup_sel, prot_sel, scr_sel, ram_sel}, sel);
        check("R1 R2 R3 R4 R6 phys_addr", phys_addr, ph);
        check("R7 rom_page", rom_page, m_page);
        check("R8 R9 R10 R11 mem_wr_n", mem_wr_n,
              !(m_strobe() && !wr_n && a >= 'hA000 && !denied));
        check("R9 R11 rd_ovr", rd_ovr, denied && !rd_n);
        check("R9 rd_ovr_data", rd_ovr_data, (denied && !rd_n) ? 8'hFF : 8'h00);
        check("R9 R10 viol", viol, st && is_locked(a) && !m_open);
    endtask

    task automatic tick();
        #1 compare();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; rfsh_n = 1;
        repeat (n) tick();
    endtask

    task automatic mem_rd(input logic [15:0] a, input int n);
        addr = a; mreq_n = 0; rd_n = 1; tick();
        rd_n = 0; repeat (n) tick();
        idle(1);
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d, input int n);
        addr = a; wdata = d; mreq_n = 0; tick();
        wr_n = 0; repeat (n) tick();
        idle(1);
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; iorq_n = 0; tick();
        wr_n = 0; repeat (2) tick();
        idle(1);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // Reset state: no enables, page 0 (R5, R7)
        #1;
        check("R5 reset enables", {rom_sel, shr_sel, sup_sel, prot_sel, scr_sel, ram_sel}, 0);
        check("R7 reset page", rom_page, 0);
        check("R9 reset viol", viol, 0);
        rst_n = 1;
        @(negedge clk);
        idle(2);

        mem_rd(16'h1234, 2);                 // R1
        mem_wr(16'hA555, 8'h3C, 2);          // R2
        for (int k = 0; k < 6; k++) mem_rd(16'(16'hC010 + k * 'h800), 2);  // R3, window 0 refused
        mem_wr(16'hC800, 8'h11, 2);          // R3 unprotected write
        mem_wr(16'h0100, 8'h22, 2);          // R8 ROM write
        io_wr(16'h00DC, 8'd3);               // R6
        mem_rd(16'hF123, 3);                 // R9 refused protected read
        mem_rd(16'hF850, 1);                 // R4 scratch
        mem_wr(16'hFA00, 8'h44, 2);          // R4 banked ram
        io_wr(16'h00DC, 8'd7);               // R6 ignored value
        addr = 16'hF900; mreq_n = 0; rd_n = 0; #1;
        check("R6 bank kept after 7", phys_addr, 18'(3 * 4096 + 'h900));
        @(negedge clk); idle(1);
        io_wr(16'h45DD, 8'd2);               // R7 upper byte ignored
        #1 check("R7 page loaded", rom_page, 2);
        @(negedge clk);
        mem_rd(16'h8001, 1);
        io_wr(16'h00DD, 8'd9);               // R7 ignored
        #1 check("R7 page kept after 9", rom_page, 2);
        @(negedge clk);
        // I/O strobe while memory request low: no port decode (R7)
        addr = 16'h00DD; wdata = 8'd1; mreq_n = 0; iorq_n = 0; wr_n = 0;
        tick(); tick(); idle(1);
        #1 check("R7 no decode under mreq", rom_page, 2);
        @(negedge clk);
        // Refresh never selects (R5)
        addr = 16'hF100; mreq_n = 0; rfsh_n = 0; tick(); tick(); idle(1);

        // Unlock then protected write allowed for 3 cycles (R10, R11)
        mem_rd(16'h1FFF, 1);
        mem_wr(16'hF010, 8'h5A, 3);
        mem_wr(16'hF010, 8'h5B, 3);          // closed again: refused
        // Unlock, unprotected access keeps it open, then window 0 read (R10)
        mem_wr(16'h1FFF, 8'h00, 1);
        mem_rd(16'hA010, 1);
        mem_rd(16'hE000, 1);
        mem_rd(16'hC010, 3);
        mem_rd(16'hC010, 3);                 // refused

        for (int b = 0; b < 6; b++) begin    // R6 every bank value
            io_wr(16'h00DC, 8'(b));
            mem_rd(16'hFFFF, 1);
            mem_rd(16'hF8FF, 1);
        end
        idle(2);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule